// File: doc/BRIEF.md
# SDRAM Configuration and Power-Mode Controller

This block holds the 32-bit configuration word of an SDRAM controller and runs the small state machine that moves the memory between normal operation, self-refresh and power-down. Software writes the word through a simple bus with per-byte enables, and the block returns the live value on a read port. The decoded fields drive the rest of the controller: CAS latency, internal bank count, page size and data-bus width.

The byte lane a write touches decides whether the attached memory has to be initialized again. A write that touches any of the three low lanes requests an initialization. A write to the top lane alone only changes the power-mode controls. The command sequencer is outside this block. Each power transition is shown as a held request (`cmd_req`, which names the transition through `pwr_state`) and completes on the sequencer's `cmd_ack`. Writes are accepted in every cycle. The write port has no ready signal and no back-pressure, so a write presented with `wr_en` high always takes effect at that clock edge.

Top module: `sdram_cfg_ctrl`

## Requirements
- R1: After reset `rd_data` reads 32'h0000_0620, which gives CAS latency 3, bank field 2, page field 0 and 32-bit width. `pwr_state` is NORMAL (0), and `cmd_req` and `init_start` are low.
- R2: Field positions are fixed. Bit 31 is the self-refresh request, bit 30 the power-down request, bit 29 refresh-while-powered-down, bit 14 the bus width (1 = 16-bit, drives `half_bus`), bits 11:9 the CAS latency, bits 6:4 the bank field and bits 2:0 the page field. Lane 3 holds bits 31:24 and lane 0 holds bits 7:0. Every other bit, including bit 8, reads 0 whatever was written.
- R3: In NORMAL with no pending mode request, a write whose `wr_be[2:0]` is non-zero makes `init_start` high for exactly the one cycle after the write edge.
- R4: A write with only `wr_be[3]` set never starts an initialization.
- R5: The CAS latency changes only on a lane-1 write that has bit 8 set. Any other write leaves it unchanged.
- R6: A set self-refresh bit in NORMAL leads to ENTER_SR (1), then on ack to SELF_REFRESH (2). Clearing the bit leads to EXIT_SR (3), then on ack back to NORMAL.
- R7: A set power-down bit (with bit 31 clear) in NORMAL leads to ENTER_PD (4), then on ack to POWER_DOWN (5). Clearing the bit leads to EXIT_PD (7), then on ack back to NORMAL.
- R8: With bits 31 and 30 both set, NORMAL goes to ENTER_SR and never to ENTER_PD.
- R9: In POWER_DOWN with bit 29 set, a `refresh_tick` leads to PD_REFRESH (6). Its ack leads to ENTER_PD, and that ack leads back to POWER_DOWN.
- R10: An initialization request raised in self-refresh or power-down first runs the exit transition, then pulses `init_start` in NORMAL, and after that pulse bits 31 and 30 read 0.
- R11: `cmd_req` is high exactly in states 1, 3, 4, 6 and 7. The state holds until `cmd_ack` arrives.
- R12: In POWER_DOWN with bit 29 clear, or in SELF_REFRESH, `refresh_tick` has no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, always accepted |
| wr_be | input | 4 | Per-byte write enables |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current configuration word |
| cas_lat | output | 3 | CAS latency field |
| bank_cfg | output | 3 | Bank-count field |
| page_cfg | output | 3 | Page-size field |
| half_bus | output | 1 | 1 = 16-bit data bus |
| init_start | output | 1 | One-cycle initialization start |
| refresh_tick | input | 1 | Refresh-timer threshold reached |
| cmd_req | output | 1 | Transition command pending |
| cmd_ack | input | 1 | Sequencer completed the command |
| pwr_state | output | 3 | Current power state |

## Verification
The assertions assume that `cmd_ack` is raised only while `cmd_req` is high and for a single cycle. They also assume that `refresh_tick` is a short pulse, and that no write lands in the same cycle as an `init_start` pulse unless that write also drives lane 3. The stimulus drives ack only through a task that first sees `cmd_req` high and then drops ack after one edge. The random writes keep bits 31:30 clear, and every write is separated from any expected initialization pulse by an idle cycle.

// File: rtl/sdcfg_pkg.sv
package sdcfg_pkg;
  typedef enum logic [2:0] {
    PS_NORMAL     = 3'd0,
    PS_ENTER_SR   = 3'd1,
    PS_SELF_REF   = 3'd2,
    PS_EXIT_SR    = 3'd3,
    PS_ENTER_PD   = 3'd4,
    PS_POWER_DN   = 3'd5,
    PS_PD_REFRESH = 3'd6,
    PS_EXIT_PD    = 3'd7
  } pwr_state_e;

  localparam int WORD_W   = 32;
  localparam int LANES    = WORD_W / 8;
  localparam int FIELD_W  = 3;
  localparam int SR_BIT   = 31;
  localparam int PD_BIT   = 30;
  localparam int PDR_BIT  = 29;
  localparam int HALF_BIT = 14;
  localparam int CL_LSB   = 9;
  localparam int LOCK_BIT = 8;
  localparam int BANK_LSB = 4;
  localparam int PAGE_LSB = 0;
  localparam logic [WORD_W-1:0] RSV_MASK = 32'h1FFF_B188;
endpackage

// File: rtl/sdcfg_regs.sv
module sdcfg_regs
  import sdcfg_pkg::*;
#(
  parameter logic [LANES-1:0]   INIT_LANE_MASK = 4'b0111,
  parameter logic [FIELD_W-1:0] CL_RESET       = 3'd3,
  parameter logic [FIELD_W-1:0] BANK_RESET     = 3'd2,
  parameter logic [FIELD_W-1:0] PAGE_RESET     = 3'd0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [LANES-1:0]     wr_be,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic                 init_fire,
  output logic [WORD_W-1:0]    rd_data,
  output logic                 sr_req,
  output logic                 pd_req,
  output logic                 pdr_en,
  output logic                 half_bus,
  output logic [FIELD_W-1:0]   cas_lat,
  output logic [FIELD_W-1:0]   bank_cfg,
  output logic [FIELD_W-1:0]   page_cfg,
  output logic                 init_pending
);
  localparam int TOP_LANE = LANES - 1;

  logic [LANES-1:0] lane_hit;
  logic             init_write;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (INIT_LANE_MASK[g]) begin : g_init
      assign lane_hit[g] = wr_en & wr_be[g];
    end else begin : g_plain
      assign lane_hit[g] = 1'b0;
    end
  end
  assign init_write = |lane_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_req       <= 1'b0;
      pd_req       <= 1'b0;
      pdr_en       <= 1'b0;
      half_bus     <= 1'b0;
      cas_lat      <= CL_RESET;
      bank_cfg     <= BANK_RESET;
      page_cfg     <= PAGE_RESET;
      init_pending <= 1'b0;
    end else begin
      if (init_fire) begin
        sr_req <= 1'b0;
        pd_req <= 1'b0;
      end
      if (wr_en && wr_be[TOP_LANE]) begin
        sr_req <= wr_data[SR_BIT];
        pd_req <= wr_data[PD_BIT];
        pdr_en <= wr_data[PDR_BIT];
      end
      if (wr_en && wr_be[1]) begin
        half_bus <= wr_data[HALF_BIT];
        if (wr_data[LOCK_BIT]) cas_lat <= wr_data[CL_LSB +: FIELD_W];
      end
      if (wr_en && wr_be[0]) begin
        bank_cfg <= wr_data[BANK_LSB +: FIELD_W];
        page_cfg <= wr_data[PAGE_LSB +: FIELD_W];
      end
      if (init_write)     init_pending <= 1'b1;
      else if (init_fire) init_pending <= 1'b0;
    end
  end

  always_comb begin
    rd_data                          = '0;
    rd_data[SR_BIT]                  = sr_req;
    rd_data[PD_BIT]                  = pd_req;
    rd_data[PDR_BIT]                 = pdr_en;
    rd_data[HALF_BIT]                = half_bus;
    rd_data[CL_LSB +: FIELD_W]       = cas_lat;
    rd_data[BANK_LSB +: FIELD_W]     = bank_cfg;
    rd_data[PAGE_LSB +: FIELD_W]     = page_cfg;
  end
endmodule

// File: rtl/sdcfg_pwr_fsm.sv
module sdcfg_pwr_fsm
  import sdcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sr_req,
  input  logic       pd_req,
  input  logic       pdr_en,
  input  logic       init_pending,
  input  logic       refresh_tick,
  input  logic       cmd_ack,
  output pwr_state_e state,
  output logic       cmd_req,
  output logic       init_fire
);
  pwr_state_e nxt;

  always_comb begin
    nxt       = state;
    cmd_req   = 1'b0;
    init_fire = 1'b0;
    unique case (state)
      PS_NORMAL: begin
        if (init_pending)  init_fire = 1'b1;
        else if (sr_req)   nxt = PS_ENTER_SR;
        else if (pd_req)   nxt = PS_ENTER_PD;
      end
      PS_ENTER_SR: begin
        cmd_req = 1'b1;
        if (cmd_ack) nxt = PS_SELF_REF;
      end
      PS_SELF_REF: begin
        if (init_pending || !sr_req) nxt = PS_EXIT_SR;
      end
      PS_EXIT_SR: begin
        cmd_req = 1'b1;
        if (cmd_ack) nxt = PS_NORMAL;
      end
      PS_ENTER_PD: begin
        cmd_req = 1'b1;
        if (cmd_ack) nxt = PS_POWER_DN;
      end
      PS_POWER_DN: begin
        if (init_pending || !pd_req || sr_req) nxt = PS_EXIT_PD;
        else if (pdr_en && refresh_tick)       nxt = PS_PD_REFRESH;
      end
      PS_PD_REFRESH: begin
        cmd_req = 1'b1;
        if (cmd_ack) nxt = PS_ENTER_PD;
      end
      PS_EXIT_PD: begin
        cmd_req = 1'b1;
        if (cmd_ack) nxt = PS_NORMAL;
      end
      default: nxt = PS_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PS_NORMAL;
    else        state <= nxt;
  end
endmodule

// File: rtl/sdram_cfg_ctrl.sv
module sdram_cfg_ctrl
  import sdcfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_be,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic [2:0]  cas_lat,
  output logic [2:0]  bank_cfg,
  output logic [2:0]  page_cfg,
  output logic        half_bus,
  output logic        init_start,
  input  logic        refresh_tick,
  output logic        cmd_req,
  input  logic        cmd_ack,
  output logic [2:0]  pwr_state
);
  logic       sr_req, pd_req, pdr_en, init_pending, init_fire;
  pwr_state_e state;

  sdcfg_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_be        (wr_be),
    .wr_data      (wr_data),
    .init_fire    (init_fire),
    .rd_data      (rd_data),
    .sr_req       (sr_req),
    .pd_req       (pd_req),
    .pdr_en       (pdr_en),
    .half_bus     (half_bus),
    .cas_lat      (cas_lat),
    .bank_cfg     (bank_cfg),
    .page_cfg     (page_cfg),
    .init_pending (init_pending)
  );

  sdcfg_pwr_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sr_req       (sr_req),
    .pd_req       (pd_req),
    .pdr_en       (pdr_en),
    .init_pending (init_pending),
    .refresh_tick (refresh_tick),
    .cmd_ack      (cmd_ack),
    .state        (state),
    .cmd_req      (cmd_req),
    .init_fire    (init_fire)
  );

  assign init_start = init_fire;
  assign pwr_state  = state;
endmodule

// File: rtl/sdram_cfg_ctrl_chk.sv
module sdram_cfg_ctrl_chk
  import sdcfg_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [3:0]  wr_be,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic [2:0]  cas_lat,
  input logic [2:0]  bank_cfg,
  input logic [2:0]  page_cfg,
  input logic        half_bus,
  input logic        init_start,
  input logic        refresh_tick,
  input logic        cmd_req,
  input logic        cmd_ack,
  input logic [2:0]  pwr_state
);
  assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & RSV_MASK) == 32'h0);

  assert_init_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (|wr_be[2:0]) && pwr_state == 3'd0 && !init_start && rd_data[31:30] == 2'b00)
      |=> init_start);

  assert_top_lane_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be == 4'b1000 && pwr_state == 3'd0 && !init_start) |=> !init_start);

  assert_cas_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_be[1] && wr_data[8]) |=> $stable(cas_lat));

  assert_sr_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd0 && !init_start && rd_data[31]) |=> pwr_state == 3'd1);

  assert_pd_refresh_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd6 && cmd_ack) |=> pwr_state == 3'd4);

  assert_init_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (init_start && !(wr_en && wr_be[3])) |=> rd_data[31:30] == 2'b00);

  assert_init_in_normal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |-> pwr_state == 3'd0);

  assert_wait_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_ack) |=> $stable(pwr_state));
endmodule

bind sdram_cfg_ctrl sdram_cfg_ctrl_chk u_chk (.*);

// File: tb/sdram_cfg_ctrl_test.sv
module sdram_cfg_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [2:0]  cas_lat, bank_cfg, page_cfg, pwr_state;
  logic        half_bus, init_start, cmd_req;
  logic        refresh_tick = 1'b0;
  logic        cmd_ack = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [31:0] shadow;

  always #2 clk = ~clk;

  sdram_cfg_ctrl uut (.*);

  function automatic logic [31:0] apply_wr(logic [31:0] old, logic [3:0] be, logic [31:0] d);
    logic [31:0] n = old;
    if (be[3]) n[31:29] = d[31:29];
    if (be[1]) begin
      n[14] = d[14];
      if (d[8]) n[11:9] = d[11:9];
    end
    if (be[0]) begin
      n[6:4] = d[6:4];
      n[2:0] = d[2:0];
    end
    return n;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    step();
    wr_en = 1'b0; wr_be = '0;
    shadow = apply_wr(shadow, be, d);
    chk(rd_data == shadow, "R2 readback", rd_data, shadow);
  endtask

  task automatic ack(input logic [2:0] st, input string tag);
    chk(cmd_req == 1'b1 && pwr_state == st, tag, {29'd0, pwr_state}, {29'd0, st});
    cmd_ack = 1'b1;
    step();
    cmd_ack = 1'b0;
  endtask

  task automatic st_is(input logic [2:0] st, input string tag);
    chk(pwr_state == st, tag, {29'd0, pwr_state}, {29'd0, st});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    shadow = 32'h0000_0620;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rd_data == 32'h0000_0620, "R1 reset word", rd_data, 32'h620);
    chk(cas_lat == 3 && bank_cfg == 2 && page_cfg == 0 && !half_bus, "R1 fields",
        {20'd0, cas_lat, bank_cfg, page_cfg, half_bus, 2'd0}, {20'd0, 3'd3, 3'd2, 3'd0, 1'b0, 2'd0});
    chk(pwr_state == 0 && !cmd_req && !init_start, "R1 idle", {29'd0, pwr_state}, 32'd0);

    // R4 + R2: top lane only, all ones outside mode bits
    wr(4'b1000, 32'h3FFF_FFFF);
    chk(!init_start, "R4 no init", {31'd0, init_start}, 32'd0);
    chk(rd_data == 32'h2000_0620, "R2 reserved zero", rd_data, 32'h2000_0620);

    // R5 CAS lock
    wr(4'b0010, 32'h0000_0A00);
    chk(cas_lat == 3'd3, "R5 cas kept", {29'd0, cas_lat}, 32'd3);
    chk(init_start, "R3 lane1 init", {31'd0, init_start}, 32'd1);
    step();
    wr(4'b0010, 32'h0000_4B00);
    chk(cas_lat == 3'd5 && half_bus, "R5 cas set/R2 width", {28'd0, half_bus, cas_lat}, 32'hD);
    step();

    // R3/R5/R2 random writes with bits 31:30 clear
    for (int i = 0; i < 60; i++) begin
      logic [3:0]  be = 4'($urandom);
      logic [31:0] d  = $urandom & 32'h3FFF_FFFF;
      wr(be, d);
      chk(init_start == (|be[2:0]), "R3 init on low lanes", {31'd0, init_start}, {31'd0, |be[2:0]});
      chk({cas_lat, bank_cfg, page_cfg, half_bus} == {shadow[11:9], shadow[6:4], shadow[2:0], shadow[14]},
          "R2 field outputs", {22'd0, cas_lat, bank_cfg, page_cfg, half_bus},
          {22'd0, shadow[11:9], shadow[6:4], shadow[2:0], shadow[14]});
      step();
      chk(!init_start, "R3 single cycle", {31'd0, init_start}, 32'd0);
    end

    // R6/R11/R12 self-refresh
    wr(4'b1000, 32'h8000_0000);
    st_is(3'd0, "R6 still normal");
    step();
    st_is(3'd1, "R6 enter sr");
    step(); step();
    st_is(3'd1, "R11 holds without ack");
    ack(3'd1, "R11 req in enter sr");
    st_is(3'd2, "R6 in self refresh");
    chk(!cmd_req, "R11 no req in sr", {31'd0, cmd_req}, 32'd0);
    refresh_tick = 1'b1; step(); refresh_tick = 1'b0; step();
    st_is(3'd2, "R12 tick ignored in sr");
    wr(4'b1000, 32'h0000_0000);
    step();
    st_is(3'd3, "R6 exit sr");
    ack(3'd3, "R11 req in exit sr");
    st_is(3'd0, "R6 back normal");

    // R8 both bits set
    wr(4'b1000, 32'hC000_0000);
    step();
    st_is(3'd1, "R8 sr wins");
    ack(3'd1, "R8 ack");
    // R7 power-down
    wr(4'b1000, 32'h4000_0000);
    step();
    st_is(3'd3, "R7 leaves sr");
    ack(3'd3, "R7 exit ack");
    st_is(3'd0, "R7 normal");
    step();
    st_is(3'd4, "R7 enter pd");
    ack(3'd4, "R7 enter ack");
    st_is(3'd5, "R7 in power down");
    refresh_tick = 1'b1; step(); refresh_tick = 1'b0; step();
    st_is(3'd5, "R12 tick ignored pdr off");

    // R9 refresh in power-down
    wr(4'b1000, 32'h6000_0000);
    st_is(3'd5, "R9 still pd");
    refresh_tick = 1'b1; step(); refresh_tick = 1'b0;
    st_is(3'd6, "R9 pd refresh");
    ack(3'd6, "R9 refresh ack");
    st_is(3'd4, "R9 re-enter pd");
    ack(3'd4, "R9 re-enter ack");
    st_is(3'd5, "R9 back in pd");

    // R10 init while powered down
    wr(4'b0001, 32'h0000_0031);
    chk(!init_start, "R10 no pulse in pd", {31'd0, init_start}, 32'd0);
    step();
    st_is(3'd7, "R10 exit pd first");
    chk(!init_start, "R10 no pulse in exit", {31'd0, init_start}, 32'd0);
    ack(3'd7, "R10 exit ack");
    st_is(3'd0, "R10 normal");
    chk(init_start, "R10 pulse after exit", {31'd0, init_start}, 32'd1);
    step();
    chk(!init_start && rd_data[31:30] == 2'b00, "R10 mode bits cleared",
        {30'd0, rd_data[31:30]}, 32'd0);
    step();
    st_is(3'd0, "R10 stays normal");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule